// File: doc/BRIEF.md
# Credit-Aware Virtual Channel Arbiter

This block decides which virtual channel's transmit queue may put its next packet onto a shared link. Each channel reports three per-cycle flags: it holds a packet, the credit tracker says there are enough credits for that packet, and the channel is enabled after negotiation. Only a channel with all three flags set is eligible. A channel that is short of credits is therefore skipped, and the other channels keep getting grants.

The arbiter decides only when the link says it can take a packet and no grant is outstanding. The winner is registered as a one-hot grant with a binary channel ID, which steers the packet multiplexer. The grant is held until the link reports that the packet has finished. A mode input selects a fair rotating search or a weighted policy that favours higher-numbered channels. In weighted mode each channel has a programmable number of consecutive grants per round. Channel 0 always takes part, so a link with no negotiated extra channels still serves channel 0. The arbiter sends nothing back to the queues beyond the grant.

Top module: `vc_arbiter`

## Requirements
- R1: Channel i is eligible only when ch_ready[i], ch_credit_ok[i] and its enable are all 1. An ineligible channel is never granted. A channel with ch_credit_ok=0 is passed over in favour of eligible channels.
- R2: Channel 0 is always enabled. ch_enable[0] has no effect. With ch_enable all 0, channel 0 is still granted when it is ready and has credits.
- R3: A decision is made only on a rising clock edge where link_rdy=1, grant_valid=0 and at least one channel is eligible. The grant appears on the outputs after that edge. While link_rdy=0 no grant is issued.
- R4: Once issued, grant and grant_id stay constant, whatever the channel flags do, until a rising edge with pkt_done=1. After that edge grant_valid=0 and grant is all zeros.
- R5: grant is one-hot when grant_valid=1 and zero otherwise. grant_id is the binary index of the set grant bit.
- R6: When mode=0 (round-robin), the search starts at the channel one above the last granted channel and runs upward, wrapping from NUM_CH-1 to 0. The first eligible channel found wins. After reset the last-granted channel is NUM_CH-1, so the first search starts at channel 0.
- R7: When mode=1 (weighted), the winner is the highest-numbered eligible channel that has used fewer grants than its weight in the current round. Channel i's weight is weights[i*WEIGHT_W +: WEIGHT_W]. A weight of 0 counts as 1. Grant usage counters are 0 after reset and advance only on weighted-mode grants.
- R8: In weighted mode, if channels are eligible but none has weight left, all usage counters restart the round. The winner is then chosen as in R7 with fresh counters and charged one grant.
- R9: When no channel is eligible, no grant is issued. The round-robin position and the weighted counters keep their values.
- R10: Every grant in either mode updates the last-granted channel used by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rdy | input | 1 | Link can accept a packet this cycle |
| pkt_done | input | 1 | Strobe: the granted packet has finished |
| mode | input | 1 | 0 = round-robin, 1 = weighted priority |
| weights | input | NUM_CH*WEIGHT_W | Per-channel weights, channel i at bits i*WEIGHT_W |
| ch_ready | input | NUM_CH | Channel holds a packet |
| ch_credit_ok | input | NUM_CH | Channel has enough credits for its packet |
| ch_enable | input | NUM_CH | Channel is negotiated and enabled (bit 0 ignored) |
| grant | output | NUM_CH | One-hot grant |
| grant_id | output | ID_W | Binary index of the granted channel |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
The assertions check on every cycle that the grant is one-hot and agrees with its ID, and that a new grant starts only after a cycle with link_rdy high. They also check that the new winner was eligible on the deciding edge, that the grant holds until pkt_done and drops after it, and that no grant arises when nothing is eligible. Which channel wins has to come from the bench's scenarios. These cover the round-robin rotation with wraparound and credit-starved skipping, weighted runs of consecutive grants, round reloads, zero-weight handling, the channel 0 default, and a pointer that stays put across an empty cycle.

// File: rtl/vc_arbiter_pkg.sv
package vc_arbiter_pkg;
  typedef enum logic {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_WEIGHTED    = 1'b1
  } arb_mode_e;

  localparam int DEF_NUM_CH   = 4;
  localparam int DEF_WEIGHT_W = 4;
endpackage

// File: rtl/vc_elig_mask.sv
module vc_elig_mask #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] ch_ready,
  input  logic [NUM_CH-1:0] ch_credit_ok,
  input  logic [NUM_CH-1:0] ch_enable,
  output logic [NUM_CH-1:0] elig,
  output logic              any_elig
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == 0) begin : g_default
      // the default channel is always part of arbitration
      assign elig[i] = ch_ready[i] & ch_credit_ok[i];
    end else begin : g_optional
      assign elig[i] = ch_ready[i] & ch_credit_ok[i] & ch_enable[i];
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/vc_rr_pick.sv
module vc_rr_pick #(
  parameter int NUM_CH = 4,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic [ID_W-1:0]   last_id,
  output logic [NUM_CH-1:0] pick_oh,
  output logic [ID_W-1:0]   pick_id
);
  always_comb begin
    logic found;
    int   idx;
    found   = 1'b0;
    pick_oh = '0;
    pick_id = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = int'(last_id) + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!found && elig[idx]) begin
        found        = 1'b1;
        pick_oh[idx] = 1'b1;
        pick_id      = ID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/vc_wt_pick.sv
module vc_wt_pick #(
  parameter int NUM_CH   = 4,
  parameter int WEIGHT_W = 4,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          elig,
  input  logic [NUM_CH*WEIGHT_W-1:0] weights,
  input  logic                       advance,
  output logic [NUM_CH-1:0]          pick_oh,
  output logic [ID_W-1:0]            pick_id
);
  logic [WEIGHT_W-1:0] used_q [NUM_CH];
  logic [WEIGHT_W-1:0] used_d [NUM_CH];
  logic [NUM_CH-1:0]   has_left;
  logic [NUM_CH-1:0]   cand;
  logic                reload;

  // a channel still has budget while its usage is below max(weight,1)
  for (genvar i = 0; i < NUM_CH; i++) begin : g_left
    logic [WEIGHT_W-1:0] lim;
    assign lim         = (weights[i*WEIGHT_W +: WEIGHT_W] == '0) ?
                         WEIGHT_W'(1) : weights[i*WEIGHT_W +: WEIGHT_W];
    assign has_left[i] = used_q[i] < lim;
  end

  assign reload = (elig != '0) && ((elig & has_left) == '0);
  assign cand   = reload ? elig : (elig & has_left);

  // highest-numbered candidate wins
  always_comb begin
    logic found;
    found   = 1'b0;
    pick_oh = '0;
    pick_id = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (!found && cand[i]) begin
        found      = 1'b1;
        pick_oh[i] = 1'b1;
        pick_id    = ID_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      used_d[i] = used_q[i];
      if (advance) begin
        if (reload) used_d[i] = '0;
        if (pick_oh[i]) used_d[i] = (reload ? '0 : used_q[i]) + WEIGHT_W'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[i] <= '0;
      end else if (advance) begin
        used_q[i] <= used_d[i];
      end
    end
  end
endmodule

// File: rtl/vc_arbiter.sv
module vc_arbiter
  import vc_arbiter_pkg::*;
#(
  parameter int NUM_CH   = DEF_NUM_CH,
  parameter int WEIGHT_W = DEF_WEIGHT_W,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       link_rdy,
  input  logic                       pkt_done,
  input  logic                       mode,
  input  logic [NUM_CH*WEIGHT_W-1:0] weights,
  input  logic [NUM_CH-1:0]          ch_ready,
  input  logic [NUM_CH-1:0]          ch_credit_ok,
  input  logic [NUM_CH-1:0]          ch_enable,
  output logic [NUM_CH-1:0]          grant,
  output logic [ID_W-1:0]            grant_id,
  output logic                       grant_valid
);
  localparam logic [ID_W-1:0] LAST_RST = ID_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] elig;
  logic              any_elig;
  logic [NUM_CH-1:0] rr_oh, wt_oh, sel_oh;
  logic [ID_W-1:0]   rr_id, wt_id, sel_id;
  logic              do_grant, wt_adv;
  arb_mode_e         mode_e;

  logic              busy_q, busy_d;
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [ID_W-1:0]   last_q, last_d;
  logic              state_en;

  vc_elig_mask #(.NUM_CH(NUM_CH)) u_elig (
    .ch_ready     (ch_ready),
    .ch_credit_ok (ch_credit_ok),
    .ch_enable    (ch_enable),
    .elig         (elig),
    .any_elig     (any_elig)
  );

  vc_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .elig    (elig),
    .last_id (last_q),
    .pick_oh (rr_oh),
    .pick_id (rr_id)
  );

  vc_wt_pick #(.NUM_CH(NUM_CH), .WEIGHT_W(WEIGHT_W)) u_wt (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .weights (weights),
    .advance (wt_adv),
    .pick_oh (wt_oh),
    .pick_id (wt_id)
  );

  assign mode_e   = arb_mode_e'(mode);
  assign do_grant = !busy_q && link_rdy && any_elig;
  assign wt_adv   = do_grant && (mode_e == ARB_WEIGHTED);
  assign sel_oh   = (mode_e == ARB_WEIGHTED) ? wt_oh : rr_oh;
  assign sel_id   = (mode_e == ARB_WEIGHTED) ? wt_id : rr_id;

  // next-state
  always_comb begin
    busy_d  = busy_q;
    grant_d = grant_q;
    id_d    = id_q;
    last_d  = last_q;
    if (busy_q && pkt_done) begin
      busy_d  = 1'b0;
      grant_d = '0;
    end else if (do_grant) begin
      busy_d  = 1'b1;
      grant_d = sel_oh;
      id_d    = sel_id;
      last_d  = sel_id;
    end
  end

  assign state_en = (busy_q && pkt_done) || do_grant;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      id_q    <= '0;
      last_q  <= LAST_RST;
    end else if (state_en) begin
      busy_q  <= busy_d;
      grant_q <= grant_d;
      id_q    <= id_d;
      last_q  <= last_d;
    end
  end

  assign grant       = grant_q;
  assign grant_id    = id_q;
  assign grant_valid = busy_q;
endmodule

// File: rtl/vc_arbiter_chk.sv
module vc_arbiter_chk #(
  parameter int NUM_CH = 4,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_rdy,
  input logic              pkt_done,
  input logic [NUM_CH-1:0] ch_ready,
  input logic [NUM_CH-1:0] ch_credit_ok,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] grant,
  input logic [ID_W-1:0]   grant_id,
  input logic              grant_valid
);
  logic [NUM_CH-1:0] ok_now;
  assign ok_now = ch_ready & ch_credit_ok & (ch_enable | NUM_CH'(1));

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid ? $onehot(grant) : (grant == '0));

  p_id_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[grant_id]);

  p_link_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(link_rdy));

  p_winner_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((grant & $past(ok_now)) != '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !pkt_done) |=> (grant_valid && $stable(grant) && $stable(grant_id)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && pkt_done) |=> !grant_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && ok_now == '0) |=> !grant_valid);
endmodule

bind vc_arbiter vc_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_rdy     (link_rdy),
  .pkt_done     (pkt_done),
  .ch_ready     (ch_ready),
  .ch_credit_ok (ch_credit_ok),
  .ch_enable    (ch_enable),
  .grant        (grant),
  .grant_id     (grant_id),
  .grant_valid  (grant_valid)
);

// File: tb/vc_arbiter_test.sv
module vc_arbiter_test;
  localparam int N  = 4;
  localparam int WW = 4;

  logic          clk;
  logic          rst_n;
  logic          link_rdy, pkt_done, mode;
  logic [N*WW-1:0] weights;
  logic [N-1:0]  ch_ready, ch_credit_ok, ch_enable;
  logic [N-1:0]  grant;
  logic [1:0]    grant_id;
  logic          grant_valid;

  int total = 0;
  int bad   = 0;

  vc_arbiter #(.NUM_CH(N), .WEIGHT_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .link_rdy(link_rdy), .pkt_done(pkt_done),
    .mode(mode), .weights(weights), .ch_ready(ch_ready),
    .ch_credit_ok(ch_credit_ok), .ch_enable(ch_enable),
    .grant(grant), .grant_id(grant_id), .grant_valid(grant_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode, ready, credit, enable, exp_valid, exp_id}
  localparam int NV = 30;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd0},  // R6 first search at 0
    {1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R6
    {1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd2},  // R6
    {1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R6
    {1'b0, 4'b1111, 4'b1011, 4'b1111, 1'b1, 2'd0},  // R6 wrap
    {1'b0, 4'b1111, 4'b1011, 4'b1111, 1'b1, 2'd1},  // R1
    {1'b0, 4'b1111, 4'b1011, 4'b1111, 1'b1, 2'd3},  // R1 starved ch2 skipped
    {1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0, 2'd0},  // R9 none
    {1'b0, 4'b1111, 4'b1111, 4'b0001, 1'b1, 2'd0},  // R2 only ch0
    {1'b0, 4'b1111, 4'b1111, 4'b0000, 1'b1, 2'd0},  // R2 enable bit0 ignored
    {1'b0, 4'b0110, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R6
    {1'b0, 4'b0110, 4'b0000, 4'b1111, 1'b0, 2'd0},  // R9 none, pointer kept
    {1'b0, 4'b0110, 4'b1111, 4'b1111, 1'b1, 2'd2},  // R9 continues after 1
    {1'b0, 4'b0110, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R6 wrap
    {1'b0, 4'b1111, 4'b1111, 4'b1001, 1'b1, 2'd3},  // R1 disabled skipped
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R7 w3=3
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R7
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R7
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd2},  // R7 w2=0 acts as 1
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R7 w1=2
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R7
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd0},  // R7 w0=1
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R8 reload
    {1'b1, 4'b0011, 4'b1111, 4'b1111, 1'b1, 2'd1},  // R7
    {1'b1, 4'b0001, 4'b1111, 4'b1111, 1'b1, 2'd0},  // R7
    {1'b1, 4'b0001, 4'b1111, 4'b1111, 1'b1, 2'd0},  // R8 ch0 only, reload
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd3},  // R8 ch3 refreshed
    {1'b1, 4'b1111, 4'b0111, 4'b1111, 1'b1, 2'd2},  // R1 starved ch3 skipped
    {1'b1, 4'b1111, 4'b0111, 4'b1111, 1'b1, 2'd1},  // R7
    {1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'd2}   // R10 pointer after ch1
  };

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one arbitration with link_rdy high for one edge, then release
  task automatic arb_once(input logic [15:0] v);
    @(negedge clk);
    mode         = v[15];
    ch_ready     = v[14:11];
    ch_credit_ok = v[10:7];
    ch_enable    = v[6:3];
    link_rdy     = 1'b1;
    @(negedge clk);
    link_rdy = 1'b0;
    check(grant_valid == v[2], "R3/R9 valid", int'(grant_valid), int'(v[2]));
    if (v[2]) begin
      check(grant_id == v[1:0], "R6/R7 id", int'(grant_id), int'(v[1:0]));
      check(grant == (4'b0001 << v[1:0]), "R5 onehot", int'(grant), int'(4'b0001 << v[1:0]));
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      check(grant_valid == 1'b0 && grant == '0, "R4 release", int'(grant), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_rdy = 1'b0; pkt_done = 1'b0; mode = 1'b0;
    weights = {4'd3, 4'd0, 4'd2, 4'd1};
    ch_ready = '0; ch_credit_ok = '0; ch_enable = '0;
    repeat (3) @(negedge clk);
    check(grant_valid == 1'b0 && grant == '0, "R5 reset", int'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant_valid == 1'b0, "R3 reset idle", int'(grant_valid), 0);

    for (int i = 0; i < NV; i++) arb_once(VEC[i]);

    // R3: link_rdy low, eligible channels, no grant
    @(negedge clk);
    mode = 1'b0; ch_ready = 4'b1111; ch_credit_ok = 4'b1111; ch_enable = 4'b1111;
    repeat (3) @(negedge clk);
    check(grant_valid == 1'b0, "R3 link low", int'(grant_valid), 0);
    link_rdy = 1'b1;
    @(negedge clk);
    link_rdy = 1'b0;
    check(grant_valid && grant_id == 2'd3, "R3 link high", int'(grant_id), 3);

    // R4: hold through changing flags and link_rdy
    ch_ready = 4'b0000; link_rdy = 1'b1;
    repeat (4) @(negedge clk);
    check(grant_valid && grant_id == 2'd3, "R4 hold", int'(grant_id), 3);
    ch_ready = 4'b1111; ch_credit_ok = 4'b0000;
    @(negedge clk);
    check(grant == 4'b1000, "R4 hold grant", int'(grant), 8);
    link_rdy = 1'b0; pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    check(grant_valid == 1'b0, "R4 drop", int'(grant_valid), 0);

    // R9: nothing eligible with link high keeps idle
    link_rdy = 1'b1;
    repeat (3) @(negedge clk);
    check(grant_valid == 1'b0, "R9 no credits", int'(grant_valid), 0);
    // R6 after hold: resume from ch3 -> ch0
    ch_credit_ok = 4'b1111;
    @(negedge clk);
    link_rdy = 1'b0;
    check(grant_valid && grant_id == 2'd0, "R6 after idle", int'(grant_id), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule